// File: doc/BRIEF.md
# Flash Page Program-and-Verify Sequencer

This controller writes one 32-byte page into a flash array. A start pulse captures a page address, 32 bytes of program data and a set of wait counts. The block then raises the array's write-enable strobe and runs a loop. Each pass of the loop does the following:

- It streams the working copy of the page into the array's write latches.
- It fires one programming pulse, framed by the setup, pulse and program strobes with a timed gap after each edge.
- It reads the page back under the verify strobe, one 16-bit word at a time.

From each read-back word the block recomputes which bits still have to go low. Only those bits carry a 0 into the next pass.

The loop stops in one of two ways. It ends as a success when a verify pass finds no bit still pending. It ends as a failure when the loop count reaches the configured limit. In both cases the write-enable strobe is dropped in the same cycle as a one-cycle done or fail pulse.

A bit's erased value is 1, and programming acts only on latch bits that are 0. The caller pads unused bytes of a short page with 0xFF.

Top module: `flash_pgm_verify`

## Requirements
- R1: A start is taken only while the block is idle. busy is high from the cycle after the accepting edge until the done/fail cycle, and it is low in that cycle. A start while busy has no effect.
- R2: The address, data, wait counts and loop limit are captured at the accepting edge. Changing them later does not alter the run.
- R3: The low 5 bits of the page address are treated as zero. Each pass writes the 32 working bytes to base+0 … base+31 in ascending order, one per cycle, in consecutive cycles. The first pass writes the program data as given.
- R4: Each timed phase lasts its wait value plus one cycle. Within a pass the order is: setup high (t_setup), pulse high (t_pulse), pulse low (t_pulse_rec), setup low (t_setup_rec). The pulse is only ever high while setup and write-enable are high.
- R5: Write-enable rises t_en+1 cycles before the first latch write. It is low in the done/fail cycle.
- R6: A verify phase raises the verify strobe, which is never high together with setup, and waits t_vfy_set. For words k = 0…15 in order, it then does three steps at address base+2k: a one-cycle dummy write of 0xFF, a wait of t_vfy_rd, and a one-cycle read. Bits 7:0 of the read word are byte 2k and bits 15:8 are byte 2k+1.
- R7: The new working byte is program OR NOT verify. A bit whose program value is 1, or whose cell already reads 0, is never pulsed again. A bit still reading 1 where 0 is wanted is pulsed again in the next pass.
- R8: After the read of word 15 the verify strobe drops. The block then waits t_vfy_clr and either ends or starts the next pass with a latch write.
- R9: If a pass leaves no bit pending, the run ends with a done pulse. If bits are still pending and the pass count n (starting at 1) is at least the limit, the run ends with a fail pulse; a limit of 0 acts as 1. done and fail are single-cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to program one page |
| page_addr | input | AW | Page byte address (low 5 bits ignored) |
| prog_data | input | 256 | Program data, byte i in bits 8i+7:8i |
| t_en | input | 16 | Wait after write-enable rises |
| t_setup | input | 16 | Wait after setup rises |
| t_pulse | input | 16 | Pulse width wait |
| t_pulse_rec | input | 16 | Wait after pulse falls |
| t_setup_rec | input | 16 | Wait after setup falls |
| t_vfy_set | input | 16 | Wait after verify rises |
| t_vfy_rd | input | 16 | Wait between dummy write and read |
| t_vfy_clr | input | 16 | Wait after verify falls |
| loop_max | input | 8 | Maximum number of passes |
| fl_swe | output | 1 | Array write-enable strobe |
| fl_psu | output | 1 | Program setup strobe |
| fl_prog | output | 1 | Program pulse strobe |
| fl_pv | output | 1 | Program-verify strobe |
| fl_wr | output | 1 | Byte write (latch or dummy) |
| fl_rd | output | 1 | Verify word read |
| fl_addr | output | AW | Byte address for write or read |
| fl_wdata | output | 8 | Write data |
| fl_rdata | input | 16 | Verify read data, valid in the fl_rd cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The result of a run is due a fixed number of edges after the accepting edge: t_en+1 plus L times (32+t_setup+t_pulse+t_pulse_rec+t_setup_rec+t_vfy_set+t_vfy_clr+6+16·(t_vfy_rd+3)), where L is the pass count. The bench derives L from a behavioural cell model in which each bit needs a known number of pulses. It counts edges from the start edge and samples done, fail and busy on the falling edge after each rising edge, so that a pulse arriving one cycle early or late shows up as a wrong count. The strobe gaps are time-stamped on falling edges and compared with wait+1. The model itself checks the order and address of every latch write, dummy write and read as it sees them.

// File: rtl/pvseq_pkg.sv
package pvseq_pkg;

    localparam int PV_TW = 16;   // wait counter width
    localparam int PV_NW = 8;    // pass counter width

    typedef enum logic [3:0] {
        S_IDLE, S_SWE, S_XFER, S_PSU, S_PRG, S_PRGOFF, S_PSUOFF,
        S_PVON, S_DWR, S_DWAIT, S_RD, S_PVOFF, S_END
    } pv_state_e;

    typedef struct packed {
        logic [PV_TW-1:0] t_en;
        logic [PV_TW-1:0] t_setup;
        logic [PV_TW-1:0] t_pulse;
        logic [PV_TW-1:0] t_pulse_rec;
        logic [PV_TW-1:0] t_setup_rec;
        logic [PV_TW-1:0] t_vfy_set;
        logic [PV_TW-1:0] t_vfy_rd;
        logic [PV_TW-1:0] t_vfy_clr;
        logic [PV_NW-1:0] loops;
    } pv_cfg_t;

    // a 0 in the result means the bit still has to be pulsed
    function automatic logic [7:0] reprog_byte(input logic [7:0] want, input logic [7:0] seen);
        return want | ~seen;
    endfunction

endpackage

// File: rtl/pv_wait_timer.sv
module pv_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: a running wait moves down by exactly one per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pv_page_buf.sv
module pv_page_buf import pvseq_pkg::*; #(
    parameter int BYTES = 32,
    parameter int IW    = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BYTES*8-1:0] pdata,
    input  logic [IW-1:0]      rd_idx,
    input  logic               upd,
    input  logic [IW-2:0]      upd_word,
    input  logic [15:0]        vdata,
    output logic [7:0]         rd_byte,
    output logic               upd_short
);
    localparam int WW = IW - 1;

    logic [7:0] want_q [BYTES];
    logic [7:0] work_q [BYTES];
    logic [7:0] new_lo, new_hi;

    always_comb begin
        new_lo    = reprog_byte(want_q[{upd_word, 1'b0}], vdata[7:0]);
        new_hi    = reprog_byte(want_q[{upd_word, 1'b1}], vdata[15:8]);
        upd_short = (new_lo & new_hi) != 8'hFF;
        rd_byte   = work_q[rd_idx];
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        localparam logic [WW-1:0] MYWORD = WW'(g / 2);
        localparam bit            ISHI   = (g % 2) == 1;

        always_ff @(posedge clk) begin
            if (rst) begin
                want_q[g] <= 8'hFF;
                work_q[g] <= 8'hFF;
            end else if (load) begin
                want_q[g] <= pdata[g*8 +: 8];
                work_q[g] <= pdata[g*8 +: 8];
            end else if (upd && upd_word == MYWORD) begin
                work_q[g] <= ISHI ? new_hi : new_lo;
            end
        end

        // R7: after a verify update no bit wanted at 1 is left pending
        p_no_extra_pulse_r7: assert property (@(posedge clk) disable iff (rst)
            (upd && upd_word == MYWORD) |=> ((want_q[g] & ~work_q[g]) == 8'h00));
    end

endmodule

// File: rtl/flash_pgm_verify.sv
module flash_pgm_verify import pvseq_pkg::*; #(
    parameter int AW         = 16,
    parameter int PAGE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [AW-1:0]           page_addr,
    input  logic [PAGE_BYTES*8-1:0] prog_data,
    input  logic [PV_TW-1:0]        t_en,
    input  logic [PV_TW-1:0]        t_setup,
    input  logic [PV_TW-1:0]        t_pulse,
    input  logic [PV_TW-1:0]        t_pulse_rec,
    input  logic [PV_TW-1:0]        t_setup_rec,
    input  logic [PV_TW-1:0]        t_vfy_set,
    input  logic [PV_TW-1:0]        t_vfy_rd,
    input  logic [PV_TW-1:0]        t_vfy_clr,
    input  logic [PV_NW-1:0]        loop_max,
    output logic                    fl_swe,
    output logic                    fl_psu,
    output logic                    fl_prog,
    output logic                    fl_pv,
    output logic                    fl_wr,
    output logic                    fl_rd,
    output logic [AW-1:0]           fl_addr,
    output logic [7:0]              fl_wdata,
    input  logic [15:0]             fl_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    fail
);
    localparam int IW    = $clog2(PAGE_BYTES);
    localparam int WIW   = IW - 1;
    localparam int WORDS = PAGE_BYTES / 2;
    localparam logic [AW-1:0]  OFS_MASK  = AW'(PAGE_BYTES - 1);
    localparam logic [IW-1:0]  LAST_BYTE = IW'(PAGE_BYTES - 1);
    localparam logic [WIW-1:0] LAST_WORD = WIW'(WORDS - 1);

    pv_state_e        state, state_n;
    pv_cfg_t          cfg_q, cfg_in, wsel;
    logic [AW-1:0]    base_q;
    logic [IW-1:0]    byte_idx;
    logic [WIW-1:0]   word_idx;
    logic [PV_NW-1:0] loop_n;
    logic             short_q, ok_q;
    logic             tmr_exp, tmr_load;
    logic [PV_TW-1:0] tmr_val;
    logic [7:0]       buf_byte;
    logic             buf_short;
    logic             give_up;

    assign cfg_in = '{t_en: t_en, t_setup: t_setup, t_pulse: t_pulse,
                      t_pulse_rec: t_pulse_rec, t_setup_rec: t_setup_rec,
                      t_vfy_set: t_vfy_set, t_vfy_rd: t_vfy_rd,
                      t_vfy_clr: t_vfy_clr, loops: loop_max};

    assign give_up = (loop_n >= cfg_q.loops);

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start) state_n = S_SWE;
            S_SWE:    if (tmr_exp) state_n = S_XFER;
            S_XFER:   if (byte_idx == LAST_BYTE) state_n = S_PSU;
            S_PSU:    if (tmr_exp) state_n = S_PRG;
            S_PRG:    if (tmr_exp) state_n = S_PRGOFF;
            S_PRGOFF: if (tmr_exp) state_n = S_PSUOFF;
            S_PSUOFF: if (tmr_exp) state_n = S_PVON;
            S_PVON:   if (tmr_exp) state_n = S_DWR;
            S_DWR:    state_n = S_DWAIT;
            S_DWAIT:  if (tmr_exp) state_n = S_RD;
            S_RD:     state_n = (word_idx == LAST_WORD) ? S_PVOFF : S_DWR;
            S_PVOFF:  if (tmr_exp) state_n = (!short_q || give_up) ? S_END : S_XFER;
            S_END:    state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // wait value for the phase being entered; the idle exit uses live inputs
    always_comb begin
        wsel = (state == S_IDLE) ? cfg_in : cfg_q;
        unique case (state_n)
            S_SWE:    tmr_val = wsel.t_en;
            S_PSU:    tmr_val = wsel.t_setup;
            S_PRG:    tmr_val = wsel.t_pulse;
            S_PRGOFF: tmr_val = wsel.t_pulse_rec;
            S_PSUOFF: tmr_val = wsel.t_setup_rec;
            S_PVON:   tmr_val = wsel.t_vfy_set;
            S_DWAIT:  tmr_val = wsel.t_vfy_rd;
            S_PVOFF:  tmr_val = wsel.t_vfy_clr;
            default:  tmr_val = '0;
        endcase
        tmr_load = (state_n != state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cfg_q    <= '0;
            base_q   <= '0;
            byte_idx <= '0;
            word_idx <= '0;
            loop_n   <= '0;
            short_q  <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            state <= state_n;
            unique case (state)
                S_IDLE: if (start) begin
                    cfg_q  <= cfg_in;
                    base_q <= page_addr & ~OFS_MASK;
                    loop_n <= PV_NW'(1);
                end
                S_XFER: byte_idx <= byte_idx + 1'b1;
                S_PVON: begin
                    word_idx <= '0;
                    short_q  <= 1'b0;
                end
                S_RD: begin
                    word_idx <= word_idx + 1'b1;
                    if (buf_short) short_q <= 1'b1;
                end
                S_PVOFF: if (tmr_exp) begin
                    ok_q <= !short_q;
                    if (short_q && !give_up) loop_n <= loop_n + 1'b1;
                end
                default: ;
            endcase
        end
    end

    pv_wait_timer #(.TW(PV_TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
    );

    pv_page_buf #(.BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst),
        .load(state == S_IDLE && start),
        .pdata(prog_data),
        .rd_idx(byte_idx),
        .upd(state == S_RD),
        .upd_word(word_idx),
        .vdata(fl_rdata),
        .rd_byte(buf_byte),
        .upd_short(buf_short)
    );

    always_comb begin
        fl_swe   = (state != S_IDLE) && (state != S_END);
        fl_psu   = (state == S_PSU) || (state == S_PRG) || (state == S_PRGOFF);
        fl_prog  = (state == S_PRG);
        fl_pv    = (state == S_PVON) || (state == S_DWR) || (state == S_DWAIT) || (state == S_RD);
        fl_wr    = (state == S_XFER) || (state == S_DWR);
        fl_rd    = (state == S_RD);
        fl_addr  = (state == S_XFER) ? (base_q | AW'(byte_idx)) : (base_q | AW'({word_idx, 1'b0}));
        fl_wdata = (state == S_XFER) ? buf_byte : 8'hFF;
        busy     = fl_swe;
        done     = (state == S_END) && ok_q;
        fail     = (state == S_END) && !ok_q;
    end

    // R4: the pulse sits inside setup, and setup inside write-enable
    p_pulse_framed_r4: assert property (@(posedge clk) disable iff (rst)
        fl_prog |-> (fl_psu && fl_swe));
    // R4: setup is already up on the cycle before the pulse starts
    p_setup_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_prog) |-> $past(fl_psu));
    // R6: verify never overlaps setup
    p_vfy_excl_r6: assert property (@(posedge clk) disable iff (rst)
        fl_pv |-> !fl_psu);
    // R6: reads only happen under verify that was already active
    p_read_in_vfy_r6: assert property (@(posedge clk) disable iff (rst)
        fl_rd |-> (fl_pv && $past(fl_pv)));
    // R9: result pulses are exclusive and last one cycle
    p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    p_result_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (done || fail) |=> !(done || fail || busy));
    // R5: write-enable is down while the result is reported
    p_swe_off_r5: assert property (@(posedge clk) disable iff (rst)
        (done || fail) |-> !fl_swe);
    // R1: a start while busy never aborts the run
    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done || fail));

endmodule

// File: tb/flash_pgm_verify_tb_top.sv
module flash_pgm_verify_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst, start;
    logic [15:0] page_addr;
    logic [255:0] prog_data;
    logic [15:0] t_en, t_setup, t_pulse, t_pulse_rec, t_setup_rec, t_vfy_set, t_vfy_rd, t_vfy_clr;
    logic [7:0]  loop_max;
    logic        fl_swe, fl_psu, fl_prog, fl_pv, fl_wr, fl_rd, busy, done, fail;
    logic [15:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic [15:0] fl_rdata;

    flash_pgm_verify dut_i (
        .clk(clk), .rst(rst), .start(start), .page_addr(page_addr), .prog_data(prog_data),
        .t_en(t_en), .t_setup(t_setup), .t_pulse(t_pulse), .t_pulse_rec(t_pulse_rec),
        .t_setup_rec(t_setup_rec), .t_vfy_set(t_vfy_set), .t_vfy_rd(t_vfy_rd),
        .t_vfy_clr(t_vfy_clr), .loop_max(loop_max),
        .fl_swe(fl_swe), .fl_psu(fl_psu), .fl_prog(fl_prog), .fl_pv(fl_pv),
        .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .fail(fail)
    );

    int total = 0;
    int bad   = 0;

    // behavioural array: each bit needs need[] pulses before it reads 0
    logic [7:0] mem   [256];
    logic [7:0] latch [32];
    int need [256];
    int hits [256];
    int gcyc = 0;
    int pulses, prog_rises, addr_err, vfy_err, wr_idx, v_idx;
    int t_swe_r, t_wr0, t_psu_r, t_prog_r, t_prog_f;
    logic p_swe = 1'b0, p_psu = 1'b0, p_prog = 1'b0;
    logic [15:0] exp_base = '0;

    assign fl_rdata = {mem[{fl_addr[7:1], 1'b1}], mem[{fl_addr[7:1], 1'b0}]};

    always @(negedge clk) begin
        gcyc++;
        if (fl_swe && !p_swe) t_swe_r = gcyc;
        if (fl_psu && !p_psu) t_psu_r = gcyc;
        if (fl_prog && !p_prog) begin
            t_prog_r = gcyc;
            prog_rises++;
            for (int i = 0; i < 32; i++)
                for (int b = 0; b < 8; b++)
                    if (!latch[i][b]) begin
                        pulses++;
                        hits[i*8+b]++;
                        if (hits[i*8+b] >= need[i*8+b]) mem[exp_base[7:0] + 8'(i)][b] = 1'b0;
                    end
        end
        if (!fl_prog && p_prog) t_prog_f = gcyc;
        if (fl_wr && !fl_pv) begin
            if (wr_idx == 0 && prog_rises == 0) t_wr0 = gcyc;
            if (fl_addr != exp_base + 16'(wr_idx)) addr_err++;
            latch[fl_addr[4:0]] = fl_wdata;
            wr_idx = (wr_idx + 1) % 32;
        end
        if (fl_wr && fl_pv) begin
            if (fl_wdata != 8'hFF || fl_addr != exp_base + 16'(2*v_idx)) vfy_err++;
        end
        if (fl_rd) begin
            if (fl_addr != exp_base + 16'(2*v_idx)) vfy_err++;
            v_idx = (v_idx + 1) % 16;
        end
        p_swe = fl_swe; p_psu = fl_psu; p_prog = fl_prog;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_times(input int x, y, z, a, b, g, e, h);
        t_en = 16'(x); t_setup = 16'(y); t_pulse = 16'(z); t_pulse_rec = 16'(a);
        t_setup_rec = 16'(b); t_vfy_set = 16'(g); t_vfy_rd = 16'(e); t_vfy_clr = 16'(h);
    endtask

    task automatic run_case(input logic [15:0] addr, input int seed, input int k, input int n, input bit slow);
        int x, y, z, a, b, g, e, h, lp, nf, lneed, lexp, pexp, cexp, cyc, busy_err, mm;
        bit okx;
        logic [7:0] pd [32];
        logic [7:0] pm, eb;
        if (slow) begin x=3; y=2; z=5; a=1; b=2; g=3; e=1; h=4; end
        else      begin x=0; y=0; z=0; a=0; b=0; g=0; e=0; h=0; end
        exp_base = addr & 16'hFFE0;
        for (int i = 0; i < 32; i++) begin
            pd[i] = (i >= 28) ? 8'hFF : 8'((i*37 + seed*11) ^ 8'h5A);
            pm    = (i % 5 == 0) ? 8'h81 : 8'h00;
            mem[exp_base[7:0] + 8'(i)] = ~(pd[i] & pm);   // some cells already low where 1 is wanted
            latch[i] = 8'hFF;
            prog_data[i*8 +: 8] = pd[i];
            for (int bb = 0; bb < 8; bb++) begin
                need[i*8+bb] = 1 + ((i*7 + bb*3 + seed) % k);
                hits[i*8+bb] = 0;
            end
        end
        pulses = 0; prog_rises = 0; addr_err = 0; vfy_err = 0; wr_idx = 0; v_idx = 0;
        page_addr = addr; loop_max = 8'(n);
        set_times(x, y, z, a, b, g, e, h);
        // expected outcome from the pulse-need table
        lneed = 0;
        for (int i = 0; i < 32; i++)
            for (int bb = 0; bb < 8; bb++)
                if (!pd[i][bb] && need[i*8+bb] > lneed) lneed = need[i*8+bb];
        nf   = (n < 1) ? 1 : n;
        okx  = (lneed <= nf);
        lexp = okx ? ((lneed < 1) ? 1 : lneed) : nf;
        pexp = 0;
        for (int i = 0; i < 32; i++)
            for (int bb = 0; bb < 8; bb++)
                if (!pd[i][bb]) pexp += (need[i*8+bb] < lexp) ? need[i*8+bb] : lexp;
        lp   = 32 + y + z + a + b + g + h + 6 + 16*(e + 3);
        cexp = x + 1 + lexp*lp;

        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        cyc = 0; busy_err = 0;
        forever begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (cyc == 25) begin   // R1 R2: start and new inputs while busy
                start = 1'b1; page_addr = 16'hFFFF; prog_data = '0; loop_max = 8'd9;
                set_times(7, 7, 7, 7, 7, 7, 7, 7);
            end
            if (cyc == 26) start = 1'b0;
            if (done || fail) break;
            if (!busy) busy_err++;
            if (cyc > 20000) begin
                chk(1'b0, "R9 watchdog", cyc, cexp);
                break;
            end
        end
        chk(done == okx,  "R9 done", int'(done), int'(okx));
        chk(fail == !okx, "R9 fail", int'(fail), int'(!okx));
        chk(!busy && busy_err == 0, "R1 busy window", busy_err, 0);
        chk(!fl_swe, "R5 swe low at end", int'(fl_swe), 0);
        chk(cyc == cexp, "R4 R2 total cycles", cyc, cexp);
        chk(prog_rises == lexp, "R9 pass count", prog_rises, lexp);
        chk(pulses == pexp, "R7 pulses on pending bits", pulses, pexp);
        chk(addr_err == 0, "R3 latch write order", addr_err, 0);
        chk(vfy_err == 0, "R6 verify access order", vfy_err, 0);
        chk(t_wr0 - t_swe_r == x + 1, "R5 enable lead", t_wr0 - t_swe_r, x + 1);
        chk(t_prog_r - t_psu_r == y + 1, "R4 setup gap", t_prog_r - t_psu_r, y + 1);
        chk(t_prog_f - t_prog_r == z + 1, "R4 pulse width", t_prog_f - t_prog_r, z + 1);
        mm = 0;
        for (int i = 0; i < 32; i++) begin
            pm = (i % 5 == 0) ? 8'h81 : 8'h00;
            for (int bb = 0; bb < 8; bb++) begin
                eb[bb] = pd[i][bb] ? ~(pd[i][bb] & pm[bb]) : (need[i*8+bb] <= lexp ? 1'b0 : 1'b1);
            end
            if (mem[exp_base[7:0] + 8'(i)] != eb) mm++;
        end
        chk(mm == 0, "R7 R8 final page contents", mm, 0);
        @(negedge clk);
        chk(!done && !fail && !busy, "R9 single-cycle result", int'(done | fail), 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; page_addr = '0; prog_data = '0; loop_max = 8'd1;
        set_times(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail, "R1 reset idle", int'(busy | done | fail), 0);
        chk(!(fl_swe | fl_psu | fl_prog | fl_pv | fl_wr | fl_rd), "R1 reset strobes low",
            int'(fl_swe | fl_psu | fl_prog | fl_pv | fl_wr | fl_rd), 0);
        for (int n = 0; n <= 3; n++)
            for (int k = 1; k <= 3; k++)
                for (int s = 0; s < 2; s++)
                    run_case(16'h3A00 + 16'(n*64 + k*32) + 16'h000B, n*5 + k*3 + s, k, n, bit'(s));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule